// File: doc/BRIEF.md
# Controller Command and Status Word Unit

This block sits between a host and the execution engines of a network controller. It keeps the shared 16-bit status word, which holds four event flags and the state codes of the command unit and the receive unit. Each time the host pulses the channel-attention input, the block reads the host command word from a small control block in memory. It acknowledges flags, applies the opcodes for each unit, and writes zero back to the command word. If needed, it fetches the head of the command list for the list walker. It then writes the updated status word back to memory.

The control block has four 16-bit words starting at a base address set by a parameter: the status word at offset 0, the command word at offset 1, and the low and high halves of the list head pointer at offsets 2 and 3. Memory is reached through a single-port word interface whose read data arrives one cycle after the request. Attention pulses that arrive while an earlier one is still in progress are counted and handled one after another.

Top module: `csw_unit`

## Requirements
- R1: After reset, the status word port reads 0x0010, with the command unit idle (code 0) and the receive unit suspended (code 1). No list pointer is held and `list_start` is low.
- R2: The status word holds the event flags in bits 15:12, the command-unit code in bits 11:8 and the receive-unit code in bits 7:4. Bits 3:0 are zero. It is always driven on `status_word`, and it is written to control-block offset 0 exactly once at the end of handling each attention pulse.
- R3: Handling an attention pulse starts with a read of offset 1 (the command word). The next cycle writes zero to that same offset.
- R4: The command-unit opcode is in command bits 10:8. Opcode 1 sets the command unit to active (code 2). Opcode 4 sets it to suspended (code 1) and sets flag bit 13. Every other opcode leaves it unchanged.
- R5: The receive-unit opcode is in command bits 6:4. Opcodes 1 and 2 set the receive unit to idle (code 0). Opcodes 3 and 4 set it to suspended (code 1) and set flag bit 12. Every other opcode leaves it unchanged.
- R6: Command bits 15:12 each clear the flag at the same bit position. The clear is applied before the opcodes set any flag, so acknowledging bit 12 while issuing a receive suspend leaves bit 12 set.
- R7: A pulse on `set_cmd_evt` sets flag bit 15 and a pulse on `set_frame_evt` sets flag bit 14. The flag is visible on `status_word` on the next cycle and is ORed in after any same-cycle acknowledge.
- R8: Command bit 7 requests a soft reset, which is applied after the opcodes. It returns the command unit to idle, the receive unit to suspended and all flags to zero, and drops the held pointer. Attention pulses already counted are kept.
- R9: After decoding, if the command unit is not suspended and no pointer is held, the block reads offset 2 (low half) and then offset 3 (high half). It then presents `list_head = {high, low}` and pulses `list_start` for one cycle, in the same cycle as the status write.
- R10: `list_release` drops the held pointer. While the command unit is suspended, no pointer fetch takes place.
- R11: Attention pulses are counted, up to 2^CNT_W-1 outstanding. Each counted pulse gets its own complete command-word read, clear and status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn | input | 1 | Channel attention; each high cycle counts as one pulse |
| set_cmd_evt | input | 1 | Command-finished event from the list walker (sets flag bit 15) |
| set_frame_evt | input | 1 | Frame-received event from the receive path (sets flag bit 14) |
| list_release | input | 1 | List walker has finished; drop the held pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| cu_state | output | 4 | Command-unit state code |
| ru_state | output | 4 | Receive-unit state code |
| status_word | output | 16 | Assembled status word |
| list_start | output | 1 | One-cycle start request to the list walker |
| list_head | output | 32 | Held command list pointer (all ones when none is held) |

## Verification
The hardest case to reach is a burst of attention pulses that arrive while the first is still being handled. In that case, the later pulses must each re-read a command word that the block itself has already cleared. The bench holds `attn` high for three consecutive cycles after placing a single start command in memory, and the scoreboard expects three separate status writes: one carries the command's effect and two show no change. A second hard case is a pointer fetch that happens again only after a release followed by a new start. The bench reaches it by pulsing `list_release` and moving the pointer in memory, then checking that the new head is captured on the next start.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int WORD_W = 16;
    localparam int PTR_W  = 2 * WORD_W;
    localparam logic [PTR_W-1:0] PTR_NONE = '1;

    typedef enum logic [3:0] {
        CU_IDLE   = 4'd0,
        CU_SUSP   = 4'd1,
        CU_ACTIVE = 4'd2
    } cu_state_e;

    typedef enum logic [3:0] {
        RU_IDLE  = 4'd0,
        RU_SUSP  = 4'd1,
        RU_READY = 4'd4
    } ru_state_e;

    // Event flags, most significant first (status bits 15..12).
    typedef struct packed {
        logic cmd_done;
        logic frame;
        logic cu_left;
        logic ru_left;
    } evt_flags_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_RD,
        ST_CMD_CLR,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_PTR_CAP,
        ST_STAT_WR
    } seq_state_e;

    function automatic logic [WORD_W-1:0] pack_status(
        input evt_flags_t f, input cu_state_e cu, input ru_state_e ru);
        return {f, cu, ru, 4'b0000};
    endfunction

endpackage

// File: rtl/csw_attn_queue.sv
module csw_attn_queue #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic take,
    output logic pending
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             inc;

    assign inc     = strobe && ((cnt != CNT_MAX) || take);
    assign pending = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(inc) - CNT_W'(take);
        end
    end

    // R11: a pulse that is not cancelled by a take raises the count
    a_r11_count_up: assert property (@(posedge clk) disable iff (rst)
        (strobe && !take && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R11: a take is only issued while something is pending
    a_r11_take_pending: assert property (@(posedge clk) disable iff (rst)
        take |-> pending);

endmodule

// File: rtl/csw_decode.sv
module csw_decode
    import csw_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    input  evt_flags_t        cur_flags,
    input  cu_state_e         cur_cu,
    input  ru_state_e         cur_ru,
    input  logic              ptr_held,
    output evt_flags_t        nxt_flags,
    output cu_state_e         nxt_cu,
    output ru_state_e         nxt_ru,
    output logic              soft_rst,
    output logic              need_load
);
    logic [2:0] cu_op;
    logic [2:0] ru_op;
    evt_flags_t acked;

    assign cu_op    = cmd_word[10:8];
    assign ru_op    = cmd_word[6:4];
    assign soft_rst = cmd_word[7];
    assign acked    = evt_flags_t'(cur_flags & ~cmd_word[15:12]);

    always_comb begin
        nxt_flags = acked;
        nxt_cu    = cur_cu;
        nxt_ru    = cur_ru;

        case (cu_op)
            3'd1: nxt_cu = CU_ACTIVE;
            3'd4: begin
                nxt_cu            = CU_SUSP;
                nxt_flags.cu_left = 1'b1;
            end
            default: ;
        endcase

        case (ru_op)
            3'd1, 3'd2: nxt_ru = RU_IDLE;
            3'd3, 3'd4: begin
                nxt_ru            = RU_SUSP;
                nxt_flags.ru_left = 1'b1;
            end
            default: ;
        endcase

        if (soft_rst) begin
            nxt_flags = '0;
            nxt_cu    = CU_IDLE;
            nxt_ru    = RU_SUSP;
        end
    end

    assign need_load = (nxt_cu != CU_SUSP) && (soft_rst || !ptr_held);

endmodule

// File: rtl/csw_unit.sv
module csw_unit
    import csw_pkg::*;
#(
    parameter int AW        = 8,
    parameter int BASE_ADDR = 16,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              attn,
    input  logic              set_cmd_evt,
    input  logic              set_frame_evt,
    input  logic              list_release,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [3:0]        cu_state,
    output logic [3:0]        ru_state,
    output logic [WORD_W-1:0] status_word,
    output logic              list_start,
    output logic [PTR_W-1:0]  list_head
);
    localparam logic [AW-1:0] STAT_ADDR   = AW'(BASE_ADDR);
    localparam logic [AW-1:0] CMD_ADDR    = AW'(BASE_ADDR + 1);
    localparam logic [AW-1:0] PTR_LO_ADDR = AW'(BASE_ADDR + 2);
    localparam logic [AW-1:0] PTR_HI_ADDR = AW'(BASE_ADDR + 3);

    seq_state_e        state, state_d;
    evt_flags_t        flags, dec_flags, flags_d;
    cu_state_e         cu, dec_cu;
    ru_state_e         ru, dec_ru;
    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] ptr_lo;
    logic              dec_srst, dec_load;
    logic              pending, take;

    csw_attn_queue #(.CNT_W(CNT_W)) i_queue (
        .clk     (clk),
        .rst     (rst),
        .strobe  (attn),
        .take    (take),
        .pending (pending)
    );

    csw_decode i_decode (
        .cmd_word  (mem_rdata),
        .cur_flags (flags),
        .cur_cu    (cu),
        .cur_ru    (ru),
        .ptr_held  (ptr != PTR_NONE),
        .nxt_flags (dec_flags),
        .nxt_cu    (dec_cu),
        .nxt_ru    (dec_ru),
        .soft_rst  (dec_srst),
        .need_load (dec_load)
    );

    assign take        = (state == ST_STAT_WR);
    assign status_word = pack_status(flags, cu, ru);
    assign cu_state    = cu;
    assign ru_state    = ru;
    assign list_head   = ptr;

    // Sequencer
    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE:    if (pending) state_d = ST_CMD_RD;
            ST_CMD_RD:  state_d = ST_CMD_CLR;
            ST_CMD_CLR: state_d = dec_load ? ST_PTR_LO : ST_STAT_WR;
            ST_PTR_LO:  state_d = ST_PTR_HI;
            ST_PTR_HI:  state_d = ST_PTR_CAP;
            ST_PTR_CAP: state_d = ST_STAT_WR;
            ST_STAT_WR: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Memory port
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = STAT_ADDR;
        mem_wdata = '0;
        case (state)
            ST_CMD_RD: begin
                mem_req  = 1'b1;
                mem_addr = CMD_ADDR;
            end
            ST_CMD_CLR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = CMD_ADDR;
            end
            ST_PTR_LO: begin
                mem_req  = 1'b1;
                mem_addr = PTR_LO_ADDR;
            end
            ST_PTR_HI: begin
                mem_req  = 1'b1;
                mem_addr = PTR_HI_ADDR;
            end
            ST_STAT_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = STAT_ADDR;
                mem_wdata = status_word;
            end
            default: ;
        endcase
    end

    // Flag next value: decoded result, then external events ORed last
    always_comb begin
        flags_d = (state == ST_CMD_CLR) ? dec_flags : flags;
        flags_d.cmd_done = flags_d.cmd_done | set_cmd_evt;
        flags_d.frame    = flags_d.frame    | set_frame_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            flags      <= '0;
            cu         <= CU_IDLE;
            ru         <= RU_SUSP;
            ptr        <= PTR_NONE;
            ptr_lo     <= '0;
            list_start <= 1'b0;
        end else begin
            state      <= state_d;
            flags      <= flags_d;
            list_start <= (state == ST_PTR_CAP);
            if (state == ST_CMD_CLR) begin
                cu <= dec_cu;
                ru <= dec_ru;
            end
            if (state == ST_PTR_HI) begin
                ptr_lo <= mem_rdata;
            end
            if (state == ST_PTR_CAP) begin
                ptr <= {mem_rdata, ptr_lo};
            end else if (state == ST_CMD_CLR && dec_srst) begin
                ptr <= PTR_NONE;
            end else if (list_release) begin
                ptr <= PTR_NONE;
            end
        end
    end

    // R2: state codes stay within their legal sets
    a_r2_codes_legal: assert property (@(posedge clk) disable iff (rst)
        (cu_state inside {4'd0, 4'd1, 4'd2}) && (ru_state inside {4'd0, 4'd1, 4'd4}));

    // R3: a command-word read is followed by a zero write to the same word
    a_r3_clear_after_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_addr == CMD_ADDR) |=>
        (mem_req && mem_we && mem_addr == CMD_ADDR && mem_wdata == '0));

    // R4: abort opcode suspends the command unit and raises bit 13
    a_r4_abort_flag: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD_CLR && mem_rdata[10:8] == 3'd4 && !mem_rdata[7]) |=>
        (status_word[13] && cu_state == 4'd1));

    // R5: suspend/abort opcodes suspend the receive unit and raise bit 12
    a_r5_ru_stop_flag: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD_CLR && (mem_rdata[6:4] == 3'd3 || mem_rdata[6:4] == 3'd4)
         && !mem_rdata[7]) |=> (status_word[12] && ru_state == 4'd1));

    // R9: start is a single-cycle pulse coinciding with the status write
    a_r9_start_pulse: assert property (@(posedge clk) disable iff (rst)
        list_start |=> !list_start);
    a_r9_start_with_status: assert property (@(posedge clk) disable iff (rst)
        list_start |-> (mem_req && mem_we && mem_addr == STAT_ADDR && list_head != PTR_NONE));

    // R10: no pointer fetch while the command unit is suspended
    a_r10_no_fetch_suspended: assert property (@(posedge clk) disable iff (rst)
        (cu_state == 4'd1) |-> !(mem_req && !mem_we && mem_addr == PTR_LO_ADDR));

endmodule

// File: tb/test_csw_unit.sv
module test_csw_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int BASE       = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        attn = 1'b0;
    logic        set_cmd_evt = 1'b0;
    logic        set_frame_evt = 1'b0;
    logic        list_release = 1'b0;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [3:0]  cu_state, ru_state;
    logic [15:0] status_word;
    logic        list_start;
    logic [31:0] list_head;

    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_data = '0;
    logic [15:0]   mem [0:(1<<AW)-1];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] st;
        logic        start;
        logic [31:0] head;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    csw_unit #(.AW(AW), .BASE_ADDR(BASE), .CNT_W(3)) i_csw_unit (
        .clk(clk), .rst(rst), .attn(attn),
        .set_cmd_evt(set_cmd_evt), .set_frame_evt(set_frame_evt),
        .list_release(list_release),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cu_state(cu_state), .ru_state(ru_state), .status_word(status_word),
        .list_start(list_start), .list_head(list_head)
    );

    // Memory model: one-cycle read latency, bench host writes when the block is quiet
    always_ff @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        else if (host_we)      mem[host_addr] <= host_data;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: pop an expectation at every status write
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_req && mem_we && mem_addr == AW'(BASE)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected status write", {16'h0, mem_wdata}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_wdata == e.st, {e.tag, " status"}, {16'h0, mem_wdata}, {16'h0, e.st});
                    check(list_start == e.start, {e.tag, " start"}, {31'h0, list_start}, {31'h0, e.start});
                    if (e.start)
                        check(list_head == e.head, {e.tag, " head"}, list_head, e.head);
                end
            end
        end
    end

    task automatic host_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] cmd, input logic [15:0] st,
                          input logic start, input logic [31:0] head, input string tag);
        exp_t e;
        host_write(AW'(BASE + 1), cmd);
        e.st = st; e.start = start; e.head = head; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); attn = 1'b1;
        @(negedge clk); attn = 1'b0;
        drain();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(status_word == 16'h0010, "R1 status", {16'h0, status_word}, 32'h0010);
        check(cu_state == 4'd0, "R1 cu", {28'h0, cu_state}, 0);
        check(ru_state == 4'd1, "R1 ru", {28'h0, ru_state}, 1);
        check(list_start == 1'b0, "R1 start", {31'h0, list_start}, 0);

        host_write(AW'(BASE + 2), 16'h1234);
        host_write(AW'(BASE + 3), 16'h00A0);

        // R9 first strobe with no pointer held fetches the list head
        strobe(16'h0000, 16'h0010, 1'b1, 32'h00A01234, "R9 initial fetch");
        // R4 start command unit; pointer held so no fetch
        strobe(16'h0100, 16'h0210, 1'b0, 32'h0, "R4 cu start");
        // R5 receive start
        strobe(16'h0010, 16'h0200, 1'b0, 32'h0, "R5 ru start");
        // R4 abort sets bit 13
        strobe(16'h0400, 16'h2100, 1'b0, 32'h0, "R4 cu abort");
        // R3 command word cleared in memory
        check(mem[BASE + 1] == 16'h0, "R3 cmd cleared", {16'h0, mem[BASE + 1]}, 0);
        // R5 receive abort sets bit 12
        strobe(16'h0040, 16'h3110, 1'b0, 32'h0, "R5 ru abort");

        // R10 release, then strobe while suspended: no fetch
        @(negedge clk); list_release = 1'b1;
        @(negedge clk); list_release = 1'b0;
        strobe(16'h0000, 16'h3110, 1'b0, 32'h0, "R10 suspended no fetch");

        // R7 external event flags
        @(negedge clk); set_cmd_evt = 1'b1; set_frame_evt = 1'b1;
        @(negedge clk); set_cmd_evt = 1'b0; set_frame_evt = 1'b0;
        check(status_word == 16'hF110, "R7 event flags", {16'h0, status_word}, 32'hF110);

        // R6 acknowledge bits 15 and 13
        strobe(16'hA000, 16'h5110, 1'b0, 32'h0, "R6 ack");
        // R6 ack of bit 12 with receive suspend: set wins over clear
        strobe(16'h1030, 16'h5110, 1'b0, 32'h0, "R6 clear before set");
        // R5 resume plus ack of bit 14
        strobe(16'h4020, 16'h1100, 1'b0, 32'h0, "R5 ru resume");

        // R10 after release, start fetches the new pointer
        host_write(AW'(BASE + 2), 16'hBEEF);
        host_write(AW'(BASE + 3), 16'h0007);
        strobe(16'h0100, 16'h1200, 1'b1, 32'h0007BEEF, "R10 refetch after release");

        // R8 soft reset overrides the cu opcode and forces a fetch
        strobe(16'h0180, 16'h0010, 1'b1, 32'h0007BEEF, "R8 soft reset");
        check(cu_state == 4'd0 && ru_state == 4'd1, "R8 unit codes",
              {24'h0, cu_state, ru_state}, 32'h01);

        // R11 three back-to-back pulses, each handled in turn
        host_write(AW'(BASE + 1), 16'h0100);
        e.start = 1'b0; e.head = 32'h0; e.st = 16'h0210;
        e.tag = "R11 queued 1"; exp_q.push_back(e);
        e.tag = "R11 queued 2"; exp_q.push_back(e);
        e.tag = "R11 queued 3"; exp_q.push_back(e);
        @(negedge clk); attn = 1'b1;
        repeat (3) @(negedge clk);
        attn = 1'b0;
        drain();

        // R4 R5 unused opcodes change nothing
        strobe(16'h0370, 16'h0210, 1'b0, 32'h0, "R4 R5 unused opcodes");
        check(status_word == 16'h0210, "R2 port matches written word", {16'h0, status_word}, 32'h0210);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule